// File: doc/BRIEF.md
# DMA Channel Completion Status and Interrupt

This block keeps the completion status of a single DMA channel and drives that channel's interrupt line. A channel engine reports three kinds of one-cycle event: a descriptor has completed, the last descriptor of a chain has completed, and the transfer was aborted by an error. Software issues stop and suspend commands as one-cycle pulses and sets a five-bit interrupt-enable mask. The block holds five sticky status flags. Software clears them by writing ones to a clear mask.

The flags obey precedence rules. An abort hides any completion reported in the same cycle. Stop wins over suspend, and the two never show together. A suspend request waits for the descriptor in progress to finish, then sets the suspended flag and the end-of-transfer flag together. This yields a single interrupt event. While the channel is stopped or suspended it reports idle and ignores the engine's completion pulses.

Top module: `dma_chan_status`

## Requirements
- R1: `status` bit encoding: [0] stopped, [1] suspended, [2] end of transfer, [3] end of chain, [4] channel abort. An accepted `desc_done` pulse sets bit 2, visible in the cycle after the pulse. Reset clears all bits, `irq` and `idle`.
- R2: An `abort` pulse sets bit 4 on the next cycle. A `desc_done` or `chain_done` arriving in the same cycle as `abort` is dropped, so bits 2 and 3 are not set by it.
- R3: Bits 0 and 1 are never both set. A `stop` and a `suspend` in the same cycle set only bit 0. A `stop` while bit 1 is set sets bit 0 and clears bit 1.
- R4: A `suspend` pulse is held pending until the next accepted `desc_done`, which may be in the same cycle. That completion sets bits 1 and 2 in the same cycle.
- R5: A `stop` pulse sets bit 0 in the next cycle, with no wait for a completion. A `desc_done` or `chain_done` in the same cycle as `stop` is dropped. A pending suspend is cancelled.
- R6: `irq` is high exactly when some status bit and its `irq_en` bit are both set. When a suspend completes with enables 1 and 2 set, `irq` shows one rising edge.
- R7: A `chain_done` pulse sets bit 3 on its own, independent of bit 2.
- R8: With `clr_we` high, each status bit whose `clr_mask` bit is 1 is cleared in the next cycle. Bits whose mask bit is 0 are unchanged.
- R9: When an event sets a bit in the same cycle that software clears that bit, the bit stays set.
- R10: While bit 0 or bit 1 is set, `idle` is high. While `idle` is high, `desc_done`, `chain_done` and `suspend` pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_done | input | 1 | Engine pulse: descriptor completed |
| chain_done | input | 1 | Engine pulse: final descriptor of chain completed |
| abort | input | 1 | Engine pulse: transfer aborted by error |
| stop | input | 1 | Software stop command pulse |
| suspend | input | 1 | Software suspend command pulse |
| irq_en | input | 5 | Interrupt enable, one bit per status bit |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 5 | Status bits to clear |
| status | output | 5 | Sticky status flags |
| idle | output | 1 | Channel halted by stop or suspend |
| irq | output | 1 | Level interrupt |

## Verification
Completions are driven alone, as descriptor-plus-chain pairs, and alongside an abort. This separates plain flag setting from abort suppression. Stop and suspend are issued together, separately, and with a pending suspend overtaken by a stop. These patterns distinguish precedence from pending-suspend timing. Clears that collide with new events, and completions delivered while halted, show whether set-over-clear priority and halt filtering hold. Counting rising edges of `irq` across a suspend completion shows whether the interrupt event is single.

// File: rtl/dma_chan_status.sv
module dma_chan_status #(
  parameter int NFLAG = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_done,
  input  logic             chain_done,
  input  logic             abort,
  input  logic             stop,
  input  logic             suspend,
  input  logic [NFLAG-1:0] irq_en,
  input  logic             clr_we,
  input  logic [NFLAG-1:0] clr_mask,
  output logic [NFLAG-1:0] status,
  output logic             idle,
  output logic             irq
);
  localparam int B_STOP = 0;
  localparam int B_SUSP = 1;
  localparam int B_EOT  = 2;
  localparam int B_EOC  = 3;
  localparam int B_ABT  = 4;

  logic [NFLAG-1:0] st, clr;
  logic pend, halted, desc_ok, chain_ok, set_susp;

  assign halted   = st[B_STOP] | st[B_SUSP];
  assign clr      = clr_we ? clr_mask : '0;
  assign desc_ok  = desc_done  & ~halted & ~abort & ~stop;
  assign chain_ok = chain_done & ~halted & ~abort & ~stop;
  assign set_susp = desc_ok & (pend | suspend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= '0;
      pend <= 1'b0;
    end else begin
      st[B_STOP] <= stop | (st[B_STOP] & ~clr[B_STOP]);
      st[B_SUSP] <= ~stop & (set_susp | (st[B_SUSP] & ~clr[B_SUSP]));
      st[B_EOT]  <= desc_ok  | (st[B_EOT] & ~clr[B_EOT]);
      st[B_EOC]  <= chain_ok | (st[B_EOC] & ~clr[B_EOC]);
      st[B_ABT]  <= abort    | (st[B_ABT] & ~clr[B_ABT]);
      if (stop || set_susp || halted) pend <= 1'b0;
      else if (suspend)               pend <= 1'b1;
    end
  end

  assign status = st;
  assign idle   = halted;
  assign irq    = |(st & irq_en);

  a_r2_abort_hides_eot: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !st[B_EOT]) |=> !st[B_EOT]);
  a_r2_abort_sets: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> st[B_ABT]);
  a_r3_stop_susp_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(st[B_STOP] && st[B_SUSP]));
  a_r4_susp_with_eot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[B_SUSP]) |-> $rose(st[B_EOT]));
  a_r5_stop_next: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> st[B_STOP]);
  a_r8_sticky_eot: assert property (@(posedge clk) disable iff (!rst_n)
    (st[B_EOT] && !(clr_we && clr_mask[B_EOT])) |=> st[B_EOT]);
  a_r10_halt_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !st[B_EOT]) |=> !st[B_EOT]);
endmodule

// File: tb/sim_dma_chan_status.sv
module sim_dma_chan_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic desc_done = 0, chain_done = 0, abort = 0, stop = 0, suspend = 0, clr_we = 0;
  logic [4:0] irq_en = '0, clr_mask = '0;
  logic [4:0] status;
  logic idle, irq;
  int total = 0, bad = 0, rises = 0;
  bit done = 0;
  bit prev_irq = 0;

  bit m_stop, m_susp, m_eot, m_eoc, m_abt, m_pend;

  always #4 clk = ~clk;

  dma_chan_status u0 (.clk(clk), .rst_n(rst_n), .desc_done(desc_done), .chain_done(chain_done),
    .abort(abort), .stop(stop), .suspend(suspend), .irq_en(irq_en), .clr_we(clr_we),
    .clr_mask(clr_mask), .status(status), .idle(idle), .irq(irq));

  always @(posedge clk) begin
    bit was_halted;
    if (!rst_n) begin
      {m_stop, m_susp, m_eot, m_eoc, m_abt, m_pend} = '0;
    end else begin
      was_halted = m_stop || m_susp;
      if (clr_we) begin
        if (clr_mask[0]) m_stop = 0;
        if (clr_mask[1]) m_susp = 0;
        if (clr_mask[2]) m_eot = 0;
        if (clr_mask[3]) m_eoc = 0;
        if (clr_mask[4]) m_abt = 0;
      end
      if (abort) m_abt = 1;
      if (stop) begin
        m_stop = 1; m_susp = 0; m_pend = 0;
      end else if (!was_halted) begin
        if (desc_done && !abort) begin
          m_eot = 1;
          if (m_pend || suspend) begin m_susp = 1; m_pend = 0; end
        end else if (suspend) m_pend = 1;
        if (chain_done && !abort) m_eoc = 1;
      end
    end
  end

  function automatic logic [4:0] model_st();
    return {m_abt, m_eoc, m_eot, m_susp, m_stop};
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(bit d, bit c, bit a, bit s, bit u, bit w, logic [4:0] m);
    @(negedge clk);
    if (rst_n) begin
      chk("R1 per-cycle status", status, model_st());
      chk("R6 per-cycle irq", irq, |(model_st() & irq_en));
      chk("R10 per-cycle idle", idle, m_stop | m_susp);
      if (irq && !prev_irq) rises++;
    end
    prev_irq = irq;
    desc_done = d; chain_done = c; abort = a; stop = s; suspend = u; clr_we = w; clr_mask = m;
  endtask

  task automatic idle1(); cyc(0,0,0,0,0,0,'0); endtask
  task automatic clrall(); cyc(0,0,0,0,0,1,5'h1f); idle1(); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle1();
    chk("R1 reset status", status, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset idle", idle, 0);

    irq_en = 5'h04;
    cyc(1,0,0,0,0,0,'0); idle1();
    chk("R1 desc sets eot", status, 5'h04);
    chk("R6 irq on eot", irq, 1);

    irq_en = 5'h08;
    idle1();
    chk("R6 masked irq low", irq, 0);

    cyc(0,0,0,0,0,1,5'h04); idle1();
    chk("R8 clear eot", status, 5'h00);

    cyc(1,1,0,0,0,0,'0); idle1();
    chk("R7 chain plus desc", status, 5'h0c);
    cyc(0,0,0,0,0,1,5'h08); idle1();
    chk("R8 clear only eoc", status, 5'h04);
    clrall();
    cyc(0,1,0,0,0,0,'0); idle1();
    chk("R7 chain alone", status, 5'h08);
    clrall();

    cyc(1,1,1,0,0,0,'0); idle1();
    chk("R2 abort on last write", status, 5'h10);
    clrall();

    cyc(0,0,0,1,1,0,'0); idle1();
    chk("R3 stop wins", status, 5'h01);
    chk("R10 idle when stopped", idle, 1);
    cyc(1,1,0,0,1,0,'0); idle1();
    chk("R10 ignored while stopped", status, 5'h01);
    clrall();
    chk("R10 idle released", idle, 0);

    cyc(1,0,0,1,0,0,'0); idle1();
    chk("R5 stop drops desc", status, 5'h01);
    clrall();

    irq_en = 5'h06;
    rises = 0;
    cyc(0,0,0,0,1,0,'0); idle1(); idle1();
    chk("R4 suspend waits", status, 5'h00);
    cyc(1,0,0,0,0,0,'0); idle1();
    chk("R4 susp with eot", status, 5'h06);
    idle1();
    chk("R6 single irq event", rises, 1);
    cyc(0,0,0,1,0,0,'0); idle1();
    chk("R3 stop clears susp", status, 5'h05);
    clrall();

    cyc(0,0,0,0,1,0,'0); cyc(0,0,0,1,0,0,'0); idle1();
    cyc(0,0,0,0,0,1,5'h01); idle1();
    cyc(1,0,0,0,0,0,'0); idle1();
    chk("R5 stop cancels pending suspend", status, 5'h04);
    clrall();

    cyc(1,0,0,0,0,0,'0); cyc(1,0,0,0,0,1,5'h04); idle1();
    chk("R9 set beats clear", status, 5'h04);
    cyc(0,0,1,0,0,1,5'h14); idle1();
    chk("R9 abort beats clear", status, 5'h10);
    clrall();

    repeat (3) idle1();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule